// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block is a synthesizable on-chip model of a synchronous static memory that lets reads and writes follow each other on consecutive clock edges with no idle cycle in between. An access starts on a load edge, when the address, the operation type, the byte lane mask and the chip selection are registered together. The block can then continue as a short burst: on each following advance edge, the two low address bits step on in linear order while the high bits stay fixed.

Read data is flow-through. The word for the access registered at a clock edge appears on the output during the cycle that follows that edge, with no further register in the path. Write data trails its address by one edge. The word on the data input at the next enabled edge is merged into the array under the byte mask that came with the address. Because of this, a read issued right after a write to the same word sees the new bytes.

A high clock enable freezes the whole block, memory included. The output enable acts without a clock and only controls whether read data is presented.

Top module: `zbt_sram`

## Requirements
- R1: While `rst_n` is low at a clock edge, the current access becomes deselected, so after that edge `rvalid` is 0 and `rdata` is all zeros.
- R2: At an enabled edge with `load_n` low, the block registers a new access: the address, the operation (`we_n` low = write, high = read), and the selection. The burst position is seeded from `addr[1:0]`.
- R3: At an enabled edge with `load_n` high, the burst position steps to the next value modulo 4 (1→2→3→0), and `addr[7:2]` of the access stays fixed. `we_n` is ignored on such edges and the operation stays as loaded.
- R4: The selection is sampled only on load edges and is true only when `sel_a_n`=0, `sel_b_n`=0 and `sel_c`=1. A deselected access, including its burst, reads nothing and writes nothing. Chip enable levels on advance edges have no effect.
- R5: For a selected read registered at edge N, `rdata` shows the stored word at the current burst address during the cycle after edge N.
- R6: `rvalid` is 1 only for a selected read with `oe_n` low. Whenever `rvalid` is 0, `rdata` is all zeros.
- R7: `oe_n` acts without a clock: changing it within a cycle changes `rvalid` and `rdata` in that same cycle.
- R8: For a selected write registered at edge N, the word on `wdata` at the next enabled edge is stored at that access's address. `byte_en_n` is sampled with the address (on load and advance edges alike) and applies to that later data.
- R9: Byte lane k is stored only when `byte_en_n[k]` is 0. Lane 0 covers bits 8:0, lane 1 covers 17:9, lane 2 covers 26:18 and lane 3 covers 35:27. Lanes with a 1 keep their old contents.
- R10: When `clk_en_n` is high at an edge, no register and no memory word changes. The output keeps showing the same access, and a pending write waits for the next enabled edge.
- R11: A read loaded at the edge where the previous write's data is taken returns the newly written bytes of that word.
- R12: During a write access `rvalid` stays 0 whatever the level of `oe_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low; high freezes the block |
| sel_a_n | input | 1 | Chip select A, active low, sampled on load edges |
| sel_b_n | input | 1 | Chip select B, active low, sampled on load edges |
| sel_c | input | 1 | Chip select C, active high, sampled on load edges |
| load_n | input | 1 | Low = load a new address, high = advance the burst |
| we_n | input | 1 | Operation on load edges: low = write, high = read |
| byte_en_n | input | 4 | Byte lane write enables, active low, sampled with the address |
| addr | input | 8 | Word address |
| wdata | input | 36 | Write data, taken one enabled edge after its address |
| oe_n | input | 1 | Output enable, active low, acts without a clock |
| rdata | output | 36 | Flow-through read data, zero when not valid |
| rvalid | output | 1 | High when `rdata` carries a selected read word |

## Verification
Assertions check the following on every cycle: the frozen state under a high clock enable, the burst step on advance edges and the seed value on load edges, that chip enables leave the selection alone on advance edges, and that `rvalid` never rises with `oe_n` high or during a write. The bench has to show the things that depend on memory contents. That covers whole-array write and read sweeps with the one-edge data lag, every one of the 16 byte masks, wrapping bursts with per-beat masks, a read straight after a write, a deselected write that leaves memory untouched, and a write held across frozen edges that picks up the data present at the enabling edge.

// File: rtl/zbt_pkg.sv
`timescale 1ns/1ps
// Shared types for the zero-turnaround SRAM.
// Assumes: one operation bit per access, fixed when the access is loaded.
package zbt_pkg;
    typedef enum logic {
        OP_RD = 1'b0,
        OP_WR = 1'b1
    } op_e;
endpackage

// File: rtl/zbt_ctrl.sv
`timescale 1ns/1ps
// Access register: holds the current access (base address, burst position,
// operation, selection and lane mask). It also acts as the pending-write
// register, because a write is committed at the edge after it was loaded.
// Assumes: clk_en_n freezes every register; rst_n is synchronous, active low.
module zbt_ctrl
    import zbt_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int BURST_W = 2,
    parameter int LANES   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              sel_a_n,
    input  logic              sel_b_n,
    input  logic              sel_c,
    input  logic              load_n,
    input  logic              we_n,
    input  logic [LANES-1:0]  byte_en_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              cur_sel,
    output op_e               cur_op,
    output logic [LANES-1:0]  cur_ben_n
);
    localparam int HI_W = ADDR_W - BURST_W;

    logic [HI_W-1:0]    base_q;
    logic [BURST_W-1:0] cnt_q;
    logic               sel_q;
    op_e                op_q;
    logic [LANES-1:0]   ben_q;

    // Register a new access on load edges, or step the burst on advance edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
            sel_q  <= 1'b0;
            op_q   <= OP_RD;
            ben_q  <= '1;
        end else if (!ce_n) begin
            ben_q <= byte_en_n;
            if (!load_n) begin
                base_q <= addr[ADDR_W-1:BURST_W];
                cnt_q  <= addr[BURST_W-1:0];
                sel_q  <= !sel_a_n && !sel_b_n && sel_c;
                op_q   <= we_n ? OP_RD : OP_WR;
            end else begin
                cnt_q <= cnt_q + BURST_W'(1);
            end
        end
    end

    // Present the current access to the array and to the output gate.
    always_comb begin
        cur_addr  = {base_q, cnt_q};
        cur_sel   = sel_q;
        cur_op    = op_q;
        cur_ben_n = ben_q;
    end

    // R10
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> $stable(cur_addr) && $stable(cur_sel) && $stable(cur_op) && $stable(cur_ben_n));

    // R3
    burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_n && load_n |=> cnt_q == BURST_W'($past(cnt_q) + BURST_W'(1))
                            && $stable(base_q) && $stable(cur_op));

    // R2
    load_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_n && !load_n |=> cnt_q == $past(addr[BURST_W-1:0]));

    // R4
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_n && load_n |=> $stable(cur_sel));
endmodule

// File: rtl/zbt_array.sv
`timescale 1ns/1ps
// Storage array split into byte lanes: each lane is written on its own
// under an active-low lane enable and read without a clock.
// Assumes: wr_en already includes the clock enable; no reset on contents.
module zbt_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES-1:0]        wr_ben_n,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Store this lane when the write is enabled and its lane bit is low.
        always_ff @(posedge clk) begin
            if (wr_en && !wr_ben_n[g]) begin
                mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        // Flow-through read of this lane.
        assign rd_data[g*LANE_W +: LANE_W] = mem[rd_addr];
    end
endmodule

// File: rtl/zbt_outgate.sv
`timescale 1ns/1ps
// Output gate: passes array data only for a selected read with the output
// enable low; otherwise it presents zeros. Purely combinational.
// Assumes: oe_n arrives without a clock and is not registered.
module zbt_outgate
    import zbt_pkg::*;
#(
    parameter int DATA_W = 36
) (
    input  logic              cur_sel,
    input  op_e               cur_op,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    // Qualify the read and gate the data.
    always_comb begin
        rvalid = cur_sel && (cur_op == OP_RD) && !oe_n;
        rdata  = rvalid ? arr_data : '0;
    end
endmodule

// File: rtl/zbt_sram.sv
`timescale 1ns/1ps
// Zero-turnaround flow-through synchronous SRAM, top level.
// Loads or advances an access on every enabled edge, commits write data one
// enabled edge after its address, and returns read data in the same cycle.
// Assumes: synchronous active-low reset; memory contents are not reset.
module zbt_sram
    import zbt_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int BURST_W = 2,
    parameter int LANES   = 4,
    parameter int LANE_W  = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_en_n,
    input  logic                    sel_a_n,
    input  logic                    sel_b_n,
    input  logic                    sel_c,
    input  logic                    load_n,
    input  logic                    we_n,
    input  logic [LANES-1:0]        byte_en_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    oe_n,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rvalid
);
    localparam int DATA_W = LANES * LANE_W;

    logic [ADDR_W-1:0] cur_addr;
    logic              cur_sel;
    op_e               cur_op;
    logic [LANES-1:0]  cur_ben_n;
    logic [DATA_W-1:0] arr_data;
    logic              commit;

    zbt_ctrl #(.ADDR_W(ADDR_W), .BURST_W(BURST_W), .LANES(LANES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (clk_en_n),
        .sel_a_n   (sel_a_n),
        .sel_b_n   (sel_b_n),
        .sel_c     (sel_c),
        .load_n    (load_n),
        .we_n      (we_n),
        .byte_en_n (byte_en_n),
        .addr      (addr),
        .cur_addr  (cur_addr),
        .cur_sel   (cur_sel),
        .cur_op    (cur_op),
        .cur_ben_n (cur_ben_n)
    );

    // Commit the pending write at the next enabled edge outside reset.
    always_comb commit = rst_n && !clk_en_n && cur_sel && (cur_op == OP_WR);

    zbt_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk      (clk),
        .wr_en    (commit),
        .wr_addr  (cur_addr),
        .wr_ben_n (cur_ben_n),
        .wr_data  (wdata),
        .rd_addr  (cur_addr),
        .rd_data  (arr_data)
    );

    zbt_outgate #(.DATA_W(DATA_W)) u_out (
        .cur_sel  (cur_sel),
        .cur_op   (cur_op),
        .oe_n     (oe_n),
        .arr_data (arr_data),
        .rdata    (rdata),
        .rvalid   (rvalid)
    );

    // R6
    valid_needs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> !oe_n);

    // R12
    no_valid_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_op == OP_WR |-> !rvalid);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !rvalid && rdata == '0);
endmodule

// File: tb/zbt_sram_tb.sv
`timescale 1ns/1ps
// Self-checking bench: whole-array sweeps, all byte masks, bursts, chip
// selects, output enable and clock-enable freezing.
module zbt_sram_tb;
    logic        clk = 1'b0;
    logic        rst_n, clk_en_n, sel_a_n, sel_b_n, sel_c, load_n, we_n, oe_n;
    logic [3:0]  byte_en_n;
    logic [7:0]  addr;
    logic [35:0] wdata, rdata;
    logic        rvalid;
    logic [35:0] mdl [256];
    int          n_chk = 0;
    int          n_fail = 0;

    always #2.5 clk = ~clk;

    zbt_sram u_dut (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel_a_n(sel_a_n),
        .sel_b_n(sel_b_n), .sel_c(sel_c), .load_n(load_n), .we_n(we_n),
        .byte_en_n(byte_en_n), .addr(addr), .wdata(wdata), .oe_n(oe_n),
        .rdata(rdata), .rvalid(rvalid)
    );

    function automatic logic [35:0] pat(int a, int salt);
        return (36'(a) * 36'h1_0203_0407) ^ (36'(salt) * 36'h5_A5A5_A5A5);
    endfunction

    function automatic logic [35:0] merge(logic [35:0] old, logic [35:0] nw, logic [3:0] ben);
        logic [35:0] r = old;
        for (int l = 0; l < 4; l++) if (!ben[l]) r[l*9 +: 9] = nw[l*9 +: 9];
        return r;
    endfunction

    task automatic chk(string req, logic [35:0] act, logic [35:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set(logic ld_n, logic w_n, logic [7:0] a, logic [3:0] be, logic [35:0] d);
        load_n = ld_n; we_n = w_n; addr = a; byte_en_n = be; wdata = d;
    endtask

    task automatic selon();
        sel_a_n = 1'b0; sel_b_n = 1'b0; sel_c = 1'b1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; clk_en_n = 1'b0; oe_n = 1'b0; selon();
        set(1'b0, 1'b1, 8'h00, 4'h0, '0);
        tick(); tick(); tick();
        // R1: reset leaves no active access
        chk("R1 rvalid", 36'(rvalid), 36'd0);
        chk("R1 rdata", rdata, 36'd0);
        rst_n = 1'b1;

        // R8 R2 R5: pipelined writes over the whole array, then reads
        for (int a = 0; a < 256; a++) begin
            set(1'b0, 1'b0, 8'(a), 4'h0, pat(a - 1, 1));
            tick();
            if (a > 0) mdl[a-1] = pat(a - 1, 1);
            chk("R12 rvalid during write", 36'(rvalid), 36'd0);
        end
        for (int a = 0; a < 256; a++) begin
            set(1'b0, 1'b1, 8'(a), 4'h0, pat(255, 1));
            tick();
            if (a == 0) mdl[255] = pat(255, 1);
            chk("R5 R8 sweep read", rdata, mdl[a]);
            chk("R6 rvalid on read", 36'(rvalid), 36'd1);
        end

        // R9: every byte mask on its own word
        for (int m = 0; m <= 16; m++) begin
            if (m < 16) set(1'b0, 1'b0, 8'(16 + m), 4'(m), pat(m - 1, 2));
            else set(1'b0, 1'b1, 8'h00, 4'h0, pat(15, 2));
            tick();
            if (m > 0) mdl[16 + m - 1] = merge(mdl[16 + m - 1], pat(m - 1, 2), 4'(m - 1));
        end
        for (int m = 0; m < 16; m++) begin
            set(1'b0, 1'b1, 8'(16 + m), 4'h0, '0);
            tick();
            chk("R9 lane mask", rdata, mdl[16 + m]);
        end

        // R3: burst read wraps and ignores we_n and chip selects while advancing
        set(1'b0, 1'b1, 8'h42, 4'h0, '0);
        tick();
        chk("R2 burst seed", rdata, mdl[8'h42]);
        for (int k = 1; k <= 4; k++) begin
            set(1'b1, 1'b0, 8'hFF, 4'h0, '0);
            sel_a_n = 1'b1; sel_c = 1'b0;
            tick();
            chk("R3 burst step", rdata, mdl[{6'h10, 2'(2 + k)}]);
            chk("R4 select kept on advance", 36'(rvalid), 36'd1);
        end
        selon();

        // R8 R9: burst write with per-beat masks
        set(1'b0, 1'b0, 8'h81, 4'h0, '0); tick();
        set(1'b1, 1'b1, 8'h00, 4'b0011, pat(1, 3)); tick();
        mdl[8'h81] = pat(1, 3);
        set(1'b1, 1'b1, 8'h00, 4'b1100, pat(2, 3)); tick();
        mdl[8'h82] = merge(mdl[8'h82], pat(2, 3), 4'b0011);
        set(1'b1, 1'b1, 8'h00, 4'b0101, pat(3, 3)); tick();
        mdl[8'h83] = merge(mdl[8'h83], pat(3, 3), 4'b1100);
        set(1'b0, 1'b1, 8'h81, 4'h0, pat(4, 3)); tick();
        mdl[8'h80] = merge(mdl[8'h80], pat(4, 3), 4'b0101);
        chk("R8 burst write beat 0", rdata, mdl[8'h81]);
        for (int k = 1; k < 4; k++) begin
            set(1'b1, 1'b1, 8'h00, 4'h0, '0); tick();
            chk("R9 burst write beat", rdata, mdl[{6'h20, 2'(1 + k)}]);
        end

        // R11: read right after write to the same word
        set(1'b0, 1'b0, 8'h10, 4'b1010, '0); tick();
        set(1'b0, 1'b1, 8'h10, 4'h0, pat(7, 4)); tick();
        mdl[8'h10] = merge(mdl[8'h10], pat(7, 4), 4'b1010);
        chk("R11 read after write", rdata, mdl[8'h10]);

        // R4: each chip select alone deselects
        for (int c = 0; c < 3; c++) begin
            selon();
            if (c == 0) sel_a_n = 1'b1;
            if (c == 1) sel_b_n = 1'b1;
            if (c == 2) sel_c = 1'b0;
            set(1'b0, 1'b1, 8'h05, 4'h0, '0); tick();
            chk("R4 deselect rvalid", 36'(rvalid), 36'd0);
            chk("R4 deselect rdata", rdata, 36'd0);
        end
        // R4: deselected write and its burst change nothing
        sel_c = 1'b0;
        set(1'b0, 1'b0, 8'h05, 4'h0, '0); tick();
        selon();
        set(1'b1, 1'b0, 8'h00, 4'h0, ~pat(5, 1)); tick();
        set(1'b0, 1'b1, 8'h05, 4'h0, ~pat(6, 1)); tick();
        chk("R4 deselected write ignored", rdata, mdl[8'h05]);
        set(1'b0, 1'b1, 8'h06, 4'h0, '0); tick();
        chk("R4 deselected burst ignored", rdata, mdl[8'h06]);

        // R7: output enable acts within the cycle
        set(1'b0, 1'b1, 8'h07, 4'h0, '0); tick();
        oe_n = 1'b1; #1;
        chk("R7 oe high rvalid", 36'(rvalid), 36'd0);
        chk("R6 oe high rdata", rdata, 36'd0);
        oe_n = 1'b0; #1;
        chk("R7 oe low data", rdata, mdl[8'h07]);

        // R12: write access with oe low shows nothing
        set(1'b0, 1'b0, 8'h30, 4'hF, '0); tick();
        chk("R12 write no rvalid", 36'(rvalid), 36'd0);

        // R10: frozen edges keep the access
        set(1'b0, 1'b1, 8'h20, 4'h0, '0); tick();
        clk_en_n = 1'b1;
        set(1'b0, 1'b1, 8'h31, 4'h0, '0); tick();
        chk("R10 load frozen", rdata, mdl[8'h20]);
        set(1'b1, 1'b1, 8'h31, 4'h0, '0); tick();
        chk("R10 advance frozen", rdata, mdl[8'h20]);
        // R10: pending write waits for the enabling edge
        clk_en_n = 1'b0;
        set(1'b0, 1'b0, 8'h21, 4'h0, '0); tick();
        clk_en_n = 1'b1;
        set(1'b0, 1'b1, 8'h00, 4'h0, pat(9, 9)); tick(); tick();
        clk_en_n = 1'b0;
        set(1'b0, 1'b1, 8'h21, 4'h0, pat(8, 8)); tick();
        mdl[8'h21] = pat(8, 8);
        chk("R10 held write data", rdata, mdl[8'h21]);

        // R1: reset mid-run drops the active read
        rst_n = 1'b0; tick(); rst_n = 1'b1;
        chk("R1 reset mid-run", 36'(rvalid), 36'd0);

        finish_run();
    end
endmodule